// File: doc/BRIEF.md
# Cluster Last-Lane Branch Selector

This block resolves a "jump for all but the last lane" branch over a wide lane group. The lane group is divided into equal clusters of eight lanes. Given the mask of lanes that are currently active, the block picks the lowest-numbered cluster that holds any active lane. It then marks every active lane of that cluster for the jump, except the highest-numbered active one.

The instruction carries a three-bit cluster-size code. Its nominal meaning is a size of two shifted left by the code, and encoders normally write 2. The block does not use the code: clusters are always eight lanes wide.

One request is accepted per cycle on `in_valid`. One cycle later the block presents a registered per-lane jump mask, a flag that is high when any lane jumps, and the 32-bit branch target, together with `out_valid`. Program-counter update and divergence tracking belong to the surrounding sequencer.

Top module: `cluster_getlast_sel`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first request, `out_valid` is 0, `jump_mask` is all zeros and `any_jump` is 0.
- R2: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high. A request's results appear on the outputs in that same cycle.
- R3: Only the lowest-indexed cluster with at least one active lane can contribute to `jump_mask`. Cluster c covers lanes 8c to 8c+7. Bits outside that cluster are 0.
- R4: Within the selected cluster, every active lane below the highest-indexed active lane has its `jump_mask` bit set. The highest-indexed active lane has its bit clear.
- R5: A lane whose `active_mask` bit is 0 never has its `jump_mask` bit set.
- R6: If the selected cluster has exactly one active lane, `jump_mask` is all zeros and `any_jump` is 0.
- R7: If `active_mask` is all zeros, `jump_mask` is all zeros and `any_jump` is 0.
- R8: `size_code` has no effect. Every one of its eight values gives the same outputs for the same active mask.
- R9: When `out_valid` is high, `any_jump` is 1 exactly when `jump_mask` has at least one bit set.
- R10: `target_out` equals the `target` presented with the request.
- R11: In a cycle after one with `in_valid` low, `jump_mask`, `any_jump` and `target_out` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| active_mask | input | 64 | Active-lane mask, bit n is lane n |
| size_code | input | 3 | Cluster-size code from the instruction (unused) |
| target | input | 32 | Branch target immediate |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| jump_mask | output | 64 | Lanes that take the jump |
| any_jump | output | 1 | At least one lane jumps |
| target_out | output | 32 | Registered branch target |

## Verification
On every cycle, the assertions check four properties:
- The one-cycle strobe lag.
- That no inactive lane jumps and that at most one cluster appears in the jump mask.
- That the jump flag agrees with the mask, including the empty-mask case.
- That the outputs hold between requests.

Only the bench's scenarios can show that the chosen cluster is the lowest non-empty one and that exactly the top active lane is dropped. They also show that the size code is ignored across all its values and that the target passes through. The bench checks these against an independent lane-by-lane reference model, both for directed patterns and for a pseudo-random sweep.

// File: rtl/glsel_pkg.sv
package glsel_pkg;
    localparam int DEF_LANES  = 64;
    localparam int DEF_CLUSTER = 8;
    localparam int DEF_TGT_W  = 32;
    localparam int DEF_SIZE_W = 3;
endpackage

// File: rtl/glsel_occupancy.sv
// Per-cluster occupancy: any active lane, and two or more active lanes.
module glsel_occupancy #(
    parameter int LANES   = glsel_pkg::DEF_LANES,
    parameter int CLUSTER = glsel_pkg::DEF_CLUSTER,
    localparam int NCL    = LANES / CLUSTER
) (
    input  logic [LANES-1:0] active,
    output logic [NCL-1:0]   nonempty,
    output logic [NCL-1:0]   multi
);
    for (genvar c = 0; c < NCL; c++) begin : g_cl
        logic [CLUSTER-1:0] slice;
        assign slice       = active[c*CLUSTER +: CLUSTER];
        assign nonempty[c] = |slice;
        assign multi[c]    = ($countones(slice) > 1);
    end
endmodule

// File: rtl/glsel_pick.sv
// Lowest-index priority pick over the non-empty clusters.
module glsel_pick #(
    parameter int NCL   = 8,
    localparam int IDXW = (NCL > 1) ? $clog2(NCL) : 1
) (
    input  logic [NCL-1:0]  req,
    output logic            found,
    output logic [IDXW-1:0] idx,
    output logic [NCL-1:0]  onehot
);
    always_comb begin
        found  = 1'b0;
        idx    = '0;
        onehot = '0;
        for (int i = NCL - 1; i >= 0; i--) begin
            if (req[i]) begin
                found  = 1'b1;
                idx    = IDXW'(i);
                onehot = '0;
                onehot[i] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/glsel_lane_strip.sv
// Keeps every set bit of a cluster except the highest one.
module glsel_lane_strip #(
    parameter int CLUSTER = glsel_pkg::DEF_CLUSTER
) (
    input  logic [CLUSTER-1:0] lanes,
    output logic [CLUSTER-1:0] jump
);
    logic seen;
    always_comb begin
        jump = '0;
        seen = 1'b0;
        for (int i = CLUSTER - 1; i >= 0; i--) begin
            if (lanes[i]) begin
                jump[i] = seen;
                seen    = 1'b1;
            end
        end
    end
endmodule

// File: rtl/cluster_getlast_sel.sv
module cluster_getlast_sel #(
    parameter int LANES   = glsel_pkg::DEF_LANES,
    parameter int CLUSTER = glsel_pkg::DEF_CLUSTER,
    parameter int TGT_W   = glsel_pkg::DEF_TGT_W,
    parameter int SIZE_W  = glsel_pkg::DEF_SIZE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [LANES-1:0]  active_mask,
    input  logic [SIZE_W-1:0] size_code,
    input  logic [TGT_W-1:0]  target,
    output logic              out_valid,
    output logic [LANES-1:0]  jump_mask,
    output logic              any_jump,
    output logic [TGT_W-1:0]  target_out
);
    localparam int NCL  = LANES / CLUSTER;
    localparam int IDXW = (NCL > 1) ? $clog2(NCL) : 1;

    typedef struct packed {
        logic             vld;
        logic [LANES-1:0] mask;
        logic             any;
        logic [TGT_W-1:0] tgt;
    } state_t;

    state_t st_d, st_q;

    // Cluster size is fixed at CLUSTER lanes; the code is deliberately unused.
    logic size_unused;
    assign size_unused = ^size_code;

    logic [NCL-1:0]     nonempty_d, multi_d, pick_oh_d;
    logic               found_d;
    logic [IDXW-1:0]    pick_idx_d;
    logic [CLUSTER-1:0] sel_lanes_d, sel_jump_d;
    logic [LANES-1:0]   cand_d;

    glsel_occupancy #(.LANES(LANES), .CLUSTER(CLUSTER)) u_occ (
        .active   (active_mask),
        .nonempty (nonempty_d),
        .multi    (multi_d)
    );

    glsel_pick #(.NCL(NCL)) u_pick (
        .req    (nonempty_d),
        .found  (found_d),
        .idx    (pick_idx_d),
        .onehot (pick_oh_d)
    );

    assign sel_lanes_d = active_mask[pick_idx_d*CLUSTER +: CLUSTER];

    glsel_lane_strip #(.CLUSTER(CLUSTER)) u_strip (
        .lanes (sel_lanes_d),
        .jump  (sel_jump_d)
    );

    for (genvar c = 0; c < NCL; c++) begin : g_place
        assign cand_d[c*CLUSTER +: CLUSTER] = pick_oh_d[c] ? sel_jump_d : '0;
    end

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.mask = cand_d;
            st_d.any  = found_d & multi_d[pick_idx_d];
            st_d.tgt  = target;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid  = st_q.vld;
    assign jump_mask  = st_q.mask;
    assign any_jump   = st_q.any;
    assign target_out = st_q.tgt;

    // ---------------- assertions ----------------
    logic [NCL-1:0] out_cl_hit;
    for (genvar c = 0; c < NCL; c++) begin : g_hit
        assign out_cl_hit[c] = |jump_mask[c*CLUSTER +: CLUSTER];
    end

    p_valid_lag_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_valid_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    p_single_cluster_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(out_cl_hit));
    p_active_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ((jump_mask & ~$past(active_mask)) == '0));
    p_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && active_mask == '0) |=> (!any_jump && jump_mask == '0));
    p_flag_match_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (any_jump == (jump_mask != '0)));
    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(jump_mask) && $stable(any_jump) && $stable(target_out)));
endmodule

// File: tb/cluster_getlast_sel_tb.sv
module cluster_getlast_sel_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] active_mask = '0;
    logic [2:0]  size_code = 3'd2;
    logic [31:0] target = '0;
    logic        out_valid;
    logic [63:0] jump_mask;
    logic        any_jump;
    logic [31:0] target_out;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    cluster_getlast_sel u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .active_mask(active_mask), .size_code(size_code), .target(target),
        .out_valid(out_valid), .jump_mask(jump_mask), .any_jump(any_jump),
        .target_out(target_out)
    );

    // Reference: lowest non-empty 8-lane cluster, drop its top active lane.
    function automatic logic [63:0] ref_mask(input logic [63:0] a);
        logic [63:0] m;
        m = '0;
        for (int c = 0; c < 8; c++) begin
            if (a[c*8 +: 8] != 8'h00) begin
                int top;
                top = 0;
                for (int l = 0; l < 8; l++) if (a[c*8 + l]) top = l;
                for (int l = 0; l < top; l++) m[c*8 + l] = a[c*8 + l];
                return m;
            end
        end
        return m;
    endfunction

    task automatic chk64(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic chk1(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    // Drive one request; on return the results are on the outputs.
    task automatic apply(input logic [63:0] a, input logic [2:0] sz, input logic [31:0] t);
        @(negedge clk);
        active_mask = a; size_code = sz; target = t; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic check_full(input string req, input logic [63:0] a);
        chk64(req, jump_mask, ref_mask(a));
        chk1(req, any_jump, ref_mask(a) != '0);
        chk1(req, out_valid, 1'b1);
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        chk1("R1 valid", out_valid, 1'b0);
        chk64("R1 mask", jump_mask, '0);
        chk1("R1 any", any_jump, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk1("R1 after release", out_valid, 1'b0);
    endtask

    task automatic t_basic_r4;
        apply(64'h0000_0000_0000_00B5, 3'd2, 32'h1234_5678);
        chk64("R4 cluster0 mask", jump_mask, 64'h35);
        chk1("R4 any", any_jump, 1'b1);
        chk1("R2 valid", out_valid, 1'b1);
        chk64("R10 target", {32'h0, target_out}, {32'h0, 32'h1234_5678});
        @(negedge clk);
        chk1("R2 valid drops", out_valid, 1'b0);
    endtask

    task automatic t_lowest_r3;
        apply(64'h0000_F000_0C00_0000, 3'd2, 32'hCAFE_0001);
        chk64("R3 lowest cluster", jump_mask, 64'h0000_0000_0400_0000);
        chk1("R3 any", any_jump, 1'b1);
    endtask

    task automatic t_full_cluster_r4;
        apply(64'hFFFF_FFFF_FFFF_FFFF, 3'd2, 32'h0);
        chk64("R4 full", jump_mask, 64'h7F);
    endtask

    task automatic t_single_r6;
        apply(64'h8000_0100_0000_0000, 3'd2, 32'h55);
        chk64("R6 mask", jump_mask, '0);
        chk1("R6 any", any_jump, 1'b0);
        chk1("R6 valid", out_valid, 1'b1);
    endtask

    task automatic t_empty_r7;
        apply(64'h0, 3'd2, 32'h77);
        chk64("R7 mask", jump_mask, '0);
        chk1("R7 any", any_jump, 1'b0);
        chk64("R10 target empty", {32'h0, target_out}, {32'h0, 32'h77});
    endtask

    task automatic t_size_r8;
        for (int s = 0; s < 8; s++) begin
            apply(64'h0000_0000_00E6_0000, 3'(s), 32'h100 + 32'(s));
            chk64("R8 size ignored", jump_mask, 64'h0000_0000_0066_0000);
            chk1("R8 any", any_jump, 1'b1);
            chk64("R10 target sweep", {32'h0, target_out}, {32'h0, 32'h100 + 32'(s)});
        end
    endtask

    task automatic t_hold_r11;
        apply(64'h0300_0000_0000_0000, 3'd2, 32'hBEEF_0000);
        @(negedge clk);
        active_mask = 64'hFFFF_FFFF_FFFF_FFFF; target = 32'h0;
        repeat (2) @(negedge clk);
        chk64("R11 mask held", jump_mask, 64'h0100_0000_0000_0000);
        chk1("R11 any held", any_jump, 1'b1);
        chk64("R11 target held", {32'h0, target_out}, {32'h0, 32'hBEEF_0000});
        chk1("R11 no valid", out_valid, 1'b0);
    endtask

    task automatic t_sweep_r5;
        for (int i = 0; i < 200; i++) begin
            logic [63:0] a;
            a = {$urandom, $urandom};
            if (i % 3 == 0) a = a & {$urandom, $urandom} & {$urandom, $urandom};
            if (i % 5 == 0) a = a & (64'hFFFF_FFFF_FFFF_FFFF << (8 * (i % 8)));
            apply(a, 3'($urandom), 32'(i));
            check_full("R3 R4 R5 R9 sweep", a);
            chk64("R5 subset", jump_mask & ~a, '0);
        end
    endtask

    initial begin
        t_reset();
        t_basic_r4();
        t_lowest_r3();
        t_full_cluster_r4();
        t_single_r6();
        t_empty_r7();
        t_size_r8();
        t_hold_r11();
        t_sweep_r5();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule